// File: doc/BRIEF.md
# Fractional Peripheral Clock Divider

This block derives a slow peripheral clock enable from a fast source clock. Each divided period ends with a single-cycle high pulse on `tick_o`. Consumers sample on the source clock and act only in cycles where `tick_o` is high. The divide ratio is an integer value N, which gives N+1 source cycles per period. The fractional variants add a 5-bit fraction F on top of that. Over time this F lengthens the average period by F/32 of a source cycle.

A parameter picks one of four variants:

| Code | Variant |
|------|---------|
| 0 | 8-bit integer |
| 1 | 16-bit integer |
| 2 | 16-bit integer plus 5-bit fraction |
| 3 | 24-bit integer plus 5-bit fraction |

Software may change N and F at any time. The block captures them only at a period boundary, so a period is never cut short. Dropping the enable stops the divider cleanly. Raising it again starts a fresh period from a clean state.

Top module: `frac_clk_div`

## Requirements
- R1: The `div_int` input is taken modulo the variant's integer width: the low 8 bits for kind 0, the low 16 bits for kinds 1 and 2, and all 24 bits for kind 3. With fraction 0, an integer value N gives one `tick_o` pulse every N+1 source cycles. The first pulse comes N cycles after the first rising edge at which `en` is sampled high.
- R2: The reachable ratios are 1 to 256 for kind 0, 1 to 65536 for kinds 1 and 2, and 1 to 16777216 for kind 3. So N=255 on kind 0 gives 256 cycles, and N=65535 on a 16-bit kind gives 65536 cycles.
- R3: On kinds 2 and 3, number the periods k=0,1,2,… from the start. Period k lasts N+1+floor((k+1)·F/32)−floor(k·F/32) cycles. Period 0 is therefore never stretched, and the average ratio is N+1+F/32.
- R4: Kinds 0 and 1 ignore `div_frac` completely. Their periods are always N+1 cycles.
- R5: With N=0 and F=0, `tick_o` is high on every source cycle while enabled.
- R6: A change of `div_int` or `div_frac` in mid-period does not alter the running period. The new value governs the next period.
- R7: While `en` is low, `tick_o` is low. Re-enabling restarts counting and fraction accumulation from zero, so timing follows R1 and R3 again from period 0.
- R8: `rst` is synchronous and active high. While it is high, `tick_o` stays low even with `en` high. After release, the divider starts only at the next rising edge with `en` high.
- R9: The variant is chosen by parameter `KIND`, using the codes 0 to 3 in the table above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider enable; low clears and silences the divider |
| div_int | input | 24 | Integer divide value N (upper bits unused on narrow kinds) |
| div_frac | input | 5 | Fraction F in 1/32 steps (unused on integer-only kinds) |
| tick_o | output | 1 | One-cycle pulse at the end of each divided period |

## Verification
All four variants share one stimulus and are compared side by side. A fraction that is nonzero must stretch periods on kinds 2 and 3 but leave kinds 0 and 1 untouched. An integer value of 0x103 exposes the 8-bit truncation against the 16- and 24-bit kinds. Random (N, F) pairs run over many periods check both where each stretch falls and the average ratio. Directed cases then cover the ends of the range:
- N=0 with F=0, for divide by 1;
- N=255 and N=65535, for the full-range ratios;
- a mid-period change of N, which must not shorten the running period;
- re-enabling after a stretch-prone run, which tells a cleared accumulator from a stale one.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int FRAC_W   = 5;
  localparam int IN_INT_W = 24;

  // Variant codes; R9
  typedef enum logic [1:0] {
    DIV_INT8        = 2'd0,
    DIV_INT16       = 2'd1,
    DIV_INT16_FRAC5 = 2'd2,
    DIV_INT24_FRAC5 = 2'd3
  } div_kind_e;

  function automatic int int_width(div_kind_e kind);
    case (kind)
      DIV_INT8:                   return 8;
      DIV_INT16, DIV_INT16_FRAC5: return 16;
      default:                    return 24;
    endcase
  endfunction

  function automatic bit has_frac(div_kind_e kind);
    return (kind == DIV_INT16_FRAC5) || (kind == DIV_INT24_FRAC5);
  endfunction

endpackage

// File: rtl/fdiv_shadow.sv
module fdiv_shadow #(
  parameter int  IN_W     = 24,
  parameter int  INT_W    = 24,
  parameter int  FW       = 5,
  parameter bit  HAS_FRAC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IN_W-1:0]  int_in,
  input  logic [FW-1:0]    frac_in,
  output logic [INT_W-1:0] cur_int,
  output logic [FW-1:0]    frac_eff
);

  // Integer value is held for the whole period (R6); truncated to INT_W (R1)
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_int <= '0;
    end else if (load) begin
      cur_int <= int_in[INT_W-1:0];
    end
  end

  generate
    if (IN_W > INT_W) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^int_in[IN_W-1:INT_W];
    end
    if (HAS_FRAC) begin : g_frac
      assign frac_eff = frac_in;
    end else begin : g_nofrac
      // R4: fraction ignored on integer-only kinds
      logic unused_frac;
      assign unused_frac = ^frac_in;
      assign frac_eff    = '0;
    end
  endgenerate

  // R6: captured value changes only on a load
  a_r6_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur_int));

endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
  parameter int FW       = 5,
  parameter bit HAS_FRAC = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic          restart,
  input  logic [FW-1:0] frac_eff,
  output logic          stretch
);

  generate
    if (HAS_FRAC) begin : g_frac
      logic [FW-1:0] acc;
      logic [FW:0]   sum;
      logic          stretch_r;

      // A fresh start adds onto an empty accumulator
      assign sum = {1'b0, (restart ? {FW{1'b0}} : acc)} + {1'b0, frac_eff};

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          acc       <= '0;
          stretch_r <= 1'b0;
        end else if (step) begin
          acc       <= sum[FW-1:0];
          stretch_r <= sum[FW];
        end
      end

      assign stretch = stretch_r;

      // R3: no carry can come out of a zero fraction
      a_r3_zero_frac_no_stretch: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && frac_eff == '0) |=> !stretch);

      // R7: disabling drops any pending stretch
      a_r7_clear_drops_stretch: assert property (@(posedge clk) disable iff (rst)
        clear |=> !stretch);
    end else begin : g_nofrac
      logic unused_in;
      assign unused_in = ^{clk, rst, clear, step, restart, frac_eff};
      assign stretch   = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             reload,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == limit);

  // R1: the count never runs past the period's terminal value
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fdiv_pkg::*;
#(
  parameter div_kind_e KIND = DIV_INT24_FRAC5,
  parameter int        IN_W = IN_INT_W,
  parameter int        FW   = FRAC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [IN_W-1:0] div_int,
  input  logic [FW-1:0]   div_frac,
  output logic            tick_o
);

  localparam int INT_W    = int_width(KIND);
  localparam bit HAS_FRAC = has_frac(KIND);
  localparam int CNT_W    = INT_W + 1;

  logic             running;
  logic             start;
  logic             period_end;
  logic             load;
  logic             hit;
  logic             stretch;
  logic [INT_W-1:0] cur_int;
  logic [FW-1:0]    frac_eff;
  logic [CNT_W-1:0] limit;

  // R8: reset leaves the divider idle
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else begin
      running <= en;
    end
  end

  assign start      = en && !running;
  assign period_end = en && running && hit;
  assign load       = start || period_end;
  assign tick_o     = period_end;
  assign limit      = CNT_W'(cur_int) + CNT_W'(stretch);

  fdiv_shadow #(
    .IN_W(IN_W), .INT_W(INT_W), .FW(FW), .HAS_FRAC(HAS_FRAC)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(load),
    .int_in(div_int), .frac_in(div_frac),
    .cur_int(cur_int), .frac_eff(frac_eff)
  );

  fdiv_accum #(
    .FW(FW), .HAS_FRAC(HAS_FRAC)
  ) u_accum (
    .clk(clk), .rst(rst), .clear(!en), .step(load),
    .restart(start), .frac_eff(frac_eff), .stretch(stretch)
  );

  fdiv_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk(clk), .rst(rst), .clear(!en), .reload(load),
    .limit(limit), .hit(hit)
  );

  // R3: the first period after a start is never stretched
  a_r3_first_period_plain: assert property (@(posedge clk) disable iff (rst)
    start |=> !stretch);

endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  import fdiv_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [23:0] ival;
  logic [4:0]  fval;
  logic [3:0]  p;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  frac_clk_div #(.KIND(DIV_INT8)) i_frac_clk_div_k0 (
    .clk(clk), .rst(rst), .en(en), .div_int(ival), .div_frac(fval), .tick_o(p[0]));
  frac_clk_div #(.KIND(DIV_INT16)) i_frac_clk_div_k1 (
    .clk(clk), .rst(rst), .en(en), .div_int(ival), .div_frac(fval), .tick_o(p[1]));
  frac_clk_div #(.KIND(DIV_INT16_FRAC5)) i_frac_clk_div_k2 (
    .clk(clk), .rst(rst), .en(en), .div_int(ival), .div_frac(fval), .tick_o(p[2]));
  frac_clk_div #(.KIND(DIV_INT24_FRAC5)) i_frac_clk_div (
    .clk(clk), .rst(rst), .en(en), .div_int(ival), .div_frac(fval), .tick_o(p[3]));

  function automatic longint bmask(int kind, longint n);
    if (kind == 0) return n % 256;
    if (kind <= 2) return n % 65536;
    return n % 16777216;
  endfunction

  function automatic longint bfrac(int kind, longint f);
    return (kind >= 2) ? f : 0;
  endfunction

  // Period k length per R1/R3/R4
  function automatic longint plen(int kind, longint n, longint f, longint k);
    longint fm = bfrac(kind, f);
    return bmask(kind, n) + 1 + ((k + 1) * fm) / 32 - (k * fm) / 32;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(string req, longint n, longint f, int periods, int max_cyc);
    longint nxt [4];
    int     done[4];
    bit     all_done;
    @(negedge clk);
    en   = 1'b0;
    ival = n[23:0];
    fval = f[4:0];
    @(negedge clk);
    check(p == 4'b0, "R7", "tick while disabled", p, 0);
    @(negedge clk);
    check(p == 4'b0, "R7", "tick while disabled", p, 0);
    en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      nxt[k]  = plen(k, n, f, 0) - 1;
      done[k] = 0;
    end
    for (int c = 0; c < max_cyc; c++) begin
      @(negedge clk);
      all_done = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (done[k] < periods) begin
          bit e = (c == nxt[k]);
          if (p[k] !== e)
            check(1'b0, req, $sformatf("kind %0d cycle %0d tick", k, c), p[k], e);
          else if (e)
            check(1'b1, req, "tick", 1, 1);
          if (e) begin
            done[k]++;
            nxt[k] += plen(k, n, f, done[k]);
          end
        end
        if (done[k] < periods) all_done = 1'b0;
      end
      if (all_done) break;
    end
    for (int k = 0; k < 4; k++)
      check(done[k] == periods, req, $sformatf("kind %0d periods seen", k), done[k], periods);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    rst  = 1'b1;
    en   = 1'b1;
    ival = '0;
    fval = '0;

    // R8: held in reset, no ticks even with enable high
    repeat (3) begin
      @(negedge clk);
      check(p == 4'b0, "R8", "tick during reset", p, 0);
    end
    rst = 1'b0;
    // R5 / R8: starts at the first edge after release; divide by 1
    repeat (4) begin
      @(negedge clk);
      check(p == 4'hF, "R5", "divide by 1 tick", p, 4'hF);
    end

    // R1: plain integer ratios with zero fraction
    run_case("R1", 4, 0, 5, 200);
    // R1 / R4: truncation of 0x103 on the 8-bit kind, fraction ignored on 0 and 1
    run_case("R4", 24'h103, 7, 3, 2000);
    // R3: stretch placement and average over 32 periods
    run_case("R3", 2, 11, 32, 400);
    run_case("R3", 0, 31, 40, 200);
    // R7: re-enable after a stretch-prone run restarts from period 0
    run_case("R7", 3, 16, 3, 100);
    run_case("R7", 3, 16, 6, 100);

    // Random mix
    for (int i = 0; i < 10; i++) begin
      longint rn = $urandom_range(0, 40);
      longint rf = $urandom_range(0, 31);
      run_case("R3", rn, rf, 40, 3000);
    end

    // R2: range ends
    run_case("R2", 255, 0, 2, 1000);
    run_case("R2", 65535, 0, 1, 70000);

    // R6: mid-period change of the integer value
    @(negedge clk);
    en   = 1'b0;
    ival = 24'd9;
    fval = 5'd0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int c = 0; c < 20; c++) begin
      bit e;
      @(negedge clk);
      e = (c >= 9) && ((c - 9) % 3 == 0);
      check(p === {4{e}}, "R6", $sformatf("cycle %0d tick after reload", c), p, {4{e}});
      if (c == 3) ival = 24'd2;
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule